// File: doc/BRIEF.md
# GPIO Edge-Capture Interrupt Unit

This block owns a small bank of general-purpose pins (three by default). Each pin is either an output, driven from an output-data register, or an input. An input passes through a two-flop synchroniser, can be read back, and can be watched for one of three kinds of edge: a rising edge, a falling edge, or any change.

A watched edge sets a sticky event bit for that pin. The host clears the bit by writing a one to it. Each event bit has its own interrupt enable. The single level interrupt line stays high while any enabled event bit is set. Host software configures the block through a flat register port: writes are strobed and reads are combinational.

Register map (3-bit address, data bits above the register's width read as zero): 0 direction (1 = output), 1 output data, 2 synchronised input (read-only), 3 capture mode (2 bits per pin), 4 interrupt enable, 5 event status (write one to clear).

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset the direction, output-data, capture-mode, interrupt-enable and event-status registers all read zero. `pin_oe` and `irq` are low.
- R2: Writing address 0 sets `pin_oe` from the written bits in the next cycle. Writing address 1 sets `pin_out` the same way.
- R3: Address 2 reads the pin inputs through two flops. A change driven before clock edge k shows on the read at edge k+1 and not before.
- R4: Capture mode 01 for pin i (mode bits [2i+1:2i]) sets event bit i on a 0-to-1 transition only.
- R5: Capture mode 10 sets the event bit on a 1-to-0 transition only.
- R6: Capture mode 11 sets the event bit on either transition.
- R7: Capture mode 00 never sets the event bit.
- R8: A pin whose direction bit is 1 never sets its event bit, whatever its mode or input activity.
- R9: Event bits stay set until written with 1 at address 5. Writing 0 to a bit leaves it unchanged.
- R10: When a capture and a clear of the same bit fall in the same cycle, the bit ends set.
- R11: Event bits set regardless of enable. `irq` is high exactly when some event bit and its enable bit (address 4, bit i) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| we | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 6 | Write data |
| rdata | output | 6 | Read data for `addr` |
| pin_in | input | 3 | Pin input levels |
| pin_out | output | 3 | Pin output levels |
| pin_oe | output | 3 | Pin output enables |
| irq | output | 1 | Level interrupt to the host |

## Verification
The two actions that can land in the same cycle are a captured edge and a write-one-to-clear of the same event bit. The bench sets the bit with a first toggle. It then drives a second toggle and times the clear write so that its clock edge is the one on which the synchronised edge is registered. It judges the outcome by reading the status register afterwards: the bit must still be set. A plain clear one cycle later must then empty it.

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int N  = 3,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [2*N-1:0] wdata,
  output logic [2*N-1:0] rdata,
  input  logic [N-1:0]  pin_in,
  output logic [N-1:0]  pin_out,
  output logic [N-1:0]  pin_oe,
  output logic          irq
);
  localparam int DW = 2 * N;
  localparam logic [AW-1:0] A_DIR  = AW'(0);
  localparam logic [AW-1:0] A_DOUT = AW'(1);
  localparam logic [AW-1:0] A_DIN  = AW'(2);
  localparam logic [AW-1:0] A_MODE = AW'(3);
  localparam logic [AW-1:0] A_IEN  = AW'(4);
  localparam logic [AW-1:0] A_STS  = AW'(5);

  logic [N-1:0]  dir, dout, ien, sts, s1, s2, s3, evt, clr;
  logic [DW-1:0] mode;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir  <= '0;
      dout <= '0;
      ien  <= '0;
      mode <= '0;
    end else if (we) begin
      case (addr)
        A_DIR:   dir  <= wdata[N-1:0];
        A_DOUT:  dout <= wdata[N-1:0];
        A_MODE:  mode <= wdata;
        A_IEN:   ien  <= wdata[N-1:0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s3, s2, s1} <= '0;
    else        {s3, s2, s1} <= {s2, s1, pin_in};

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic up, dn;
    assign up = s2[i] & ~s3[i];
    assign dn = ~s2[i] & s3[i];
    always_comb
      case (mode[2*i +: 2])
        2'b01:   evt[i] = up & ~dir[i];
        2'b10:   evt[i] = dn & ~dir[i];
        2'b11:   evt[i] = (up | dn) & ~dir[i];
        default: evt[i] = 1'b0;
      endcase
  end

  assign clr = (we && addr == A_STS) ? wdata[N-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~clr) | evt;

  always_comb
    case (addr)
      A_DIR:   rdata = DW'(dir);
      A_DOUT:  rdata = DW'(dout);
      A_DIN:   rdata = DW'(s2);
      A_MODE:  rdata = mode;
      A_IEN:   rdata = DW'(ien);
      A_STS:   rdata = DW'(sts);
      default: rdata = '0;
    endcase

  assign pin_out = dout;
  assign pin_oe  = dir;
  assign irq     = |(sts & ien);
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int N  = 3,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          we,
  input logic [AW-1:0] addr,
  input logic [2*N-1:0] wdata,
  input logic [N-1:0]  pin_oe,
  input logic          irq,
  input logic [N-1:0]  sts
);
  p_oe_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == AW'(0)) |=> (pin_oe == $past(wdata[N-1:0])));

  p_out_pin_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (&pin_oe) |=> ((sts & ~$past(sts)) == '0));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == AW'(5)) |=> (($past(sts) & ~sts) == '0));

  p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(we && (addr == AW'(5) || addr == AW'(4)))) |=> irq);
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.N(N), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
  .pin_oe(pin_oe), .irq(irq), .sts(sts)
);

// File: tb/gpio_edge_irq_tb_top.sv
module gpio_edge_irq_tb_top;
  logic clk = 0, rst_n = 0, we = 0;
  logic [2:0] addr = '0, pin_in = '0, pin_out, pin_oe;
  logic [5:0] wdata = '0, rdata;
  logic irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  gpio_edge_irq dut_i (.clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  // {pin[1:0], mode[1:0], from, to, expected event}
  localparam logic [6:0] VEC [10] = '{
    {2'd0, 2'b01, 1'b0, 1'b1, 1'b1},  // R4
    {2'd1, 2'b01, 1'b1, 1'b0, 1'b0},  // R4
    {2'd2, 2'b10, 1'b1, 1'b0, 1'b1},  // R5
    {2'd0, 2'b10, 1'b0, 1'b1, 1'b0},  // R5
    {2'd1, 2'b11, 1'b0, 1'b1, 1'b1},  // R6
    {2'd2, 2'b11, 1'b1, 1'b0, 1'b1},  // R6
    {2'd0, 2'b00, 1'b0, 1'b1, 1'b0},  // R7
    {2'd2, 2'b00, 1'b1, 1'b0, 1'b0},  // R7
    {2'd1, 2'b10, 1'b1, 1'b0, 1'b1},  // R5
    {2'd2, 2'b01, 1'b0, 1'b1, 1'b1}   // R4
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [5:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [5:0] d);
    @(negedge clk); addr = a; #0.5 d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 6; a++) begin
      if (a == 2) continue;
      rd(3'(a), v); chk("R1 reg", v, 0);
    end
    chk("R1 oe", pin_oe, 0); chk("R1 irq", irq, 0);

    wr(0, 6'b101); chk("R2 oe", pin_oe, 3'b101);
    wr(1, 6'b011); chk("R2 out", pin_out, 3'b011);
    wr(0, 0); wr(1, 0);

    @(negedge clk); pin_in = 3'b010; addr = 2;
    @(posedge clk); @(negedge clk); chk("R3 early", rdata, 0);
    @(posedge clk); @(negedge clk); chk("R3 late", rdata, 6'b010);
    pin_in = 0; settle();

    foreach (VEC[k]) begin
      int p = VEC[k][6:5];
      wr(3, 6'(VEC[k][4:3]) << (2 * p));
      pin_in[p] = VEC[k][2]; settle();
      wr(5, 6'b111);
      @(negedge clk); pin_in[p] = VEC[k][1]; settle();
      rd(5, v);
      chk($sformatf("R4-7 vec%0d", k), v[p], VEC[k][0]);
      pin_in = 0; settle(); wr(5, 6'b111);
    end

    wr(3, 6'b111111); wr(0, 6'b001); wr(5, 6'b111);
    @(negedge clk); pin_in[0] = 1; settle(); pin_in[0] = 0; settle();
    rd(5, v); chk("R8 output pin", v, 0);
    wr(0, 0); wr(5, 6'b111);

    @(negedge clk); pin_in = 3'b011; settle();
    rd(5, v); chk("R6 two pins", v, 6'b011);
    wr(5, 0); rd(5, v); chk("R9 zero write", v, 6'b011);
    wr(5, 6'b001); rd(5, v); chk("R9 one clear", v, 6'b010);

    @(negedge clk); pin_in[1] = 0;
    @(posedge clk); @(negedge clk); @(posedge clk);
    @(negedge clk); we = 1; addr = 5; wdata = 6'b010;
    @(negedge clk); we = 0;
    rd(5, v); chk("R10 event beats clear", v, 6'b010);
    wr(5, 6'b010); rd(5, v); chk("R10 later clear", v, 0);

    @(negedge clk); pin_in[1] = 1; settle();
    wr(4, 6'b001); chk("R11 masked", irq, 0);
    wr(4, 6'b010); chk("R11 enabled", irq, 1);
    wr(5, 6'b010); chk("R11 cleared", irq, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule